// File: doc/BRIEF.md
# Shared Digital/Analog Port Controller

This block controls an 8-bit port whose pins are shared between general-purpose digital I/O and the analog inputs of a converter. Software programs three registers over a small read/write bus: a per-bit direction register, an output latch, and a control register that holds a global analog-disable flag and a channel-select field. From these registers the block drives the pad output values and output enables, gates the synchronised pad inputs into the digital read path, and produces a one-hot analog enable toward the converter.

Each pin's mode comes from its direction bit and its latch bit together. A set direction bit makes the pin an output. A clear direction bit with a set latch bit makes the pin a digital input. A clear direction bit with a clear latch bit makes the pin an analog input, and that pin reads as zero. Clearing the analog-disable flag starts a conversion, which the block signals with a one-cycle pulse. A status flag shows whether the alternate output function on the top bit is usable.

Top module: `mixed_io_port`

## Requirements
- R1: After reset the direction register reads 0x00, the port reads 0x00 whatever the pads carry, the control register reads 0x01 (analog-disable set, select 0), all output enables are 0 and the analog enable is 0.
- R2: The bus has three registers: address 0 is direction, address 1 is the latch on write and the port value on read, and address 2 is control, with bit 0 as the analog-disable flag and bits 3:1 as the channel select. Address 3 reads 0. A write takes effect at the clock edge where `wr_en_i` is high. Reads are combinational.
- R3: A pin whose direction bit is 1 has its output enable at 1 and drives its latch bit. Reading the port returns the latch bit for that pin. `pad_out_o` always equals the latch.
- R4: A pin with direction 0 and latch 1 reads its pad level through a two-flop synchroniser. A pad change becomes visible to reads after the second rising clock edge.
- R5: A pin with direction 0 and latch 0 always reads 0, whatever the pad level and the analog-disable flag.
- R6: `conv_start_o` is high for exactly one cycle, in the cycle after the write that changes the analog-disable flag from 1 to 0. Writing 0 while the flag is already 0, or writing 1, produces no pulse.
- R7: `ana_en_o` has at most one bit set. The bit set is the one that the channel select picks, and only while that pin has direction 0 and latch 0 and the analog-disable flag is 0.
- R8: The modes apply to each bit independently, so output, digital input and analog pins can be mixed within one port.
- R9: `dbg_ok_o` equals latch bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| pad_in_i | input | 8 | Raw pad input levels |
| pad_out_o | output | 8 | Pad output values (latch) |
| pad_oe_o | output | 8 | Pad output enables (direction) |
| ana_en_o | output | 8 | One-hot analog channel enable |
| conv_start_o | output | 1 | Conversion start pulse |
| dbg_ok_o | output | 1 | Alternate output on bit 7 usable |

## Verification
On every cycle the assertions check the following. The analog enable is at most one-hot and never falls on a driven or latch-high pin. A port read never shows a 1 on an analog-mode bit. A direction write appears on the output enables one edge later. Each start pulse has a 1-to-0 control write just before it and lasts a single cycle. The bench scenarios alone show the reset values, the two-edge input latency, the absence of a pulse on repeated or rising flag writes, the channel decode, mixed-mode reads and the debug flag.

// File: rtl/mio_pkg.sv
package mio_pkg;
  typedef enum logic [1:0] {
    A_DIR  = 2'd0,
    A_DATA = 2'd1,
    A_CTRL = 2'd2,
    A_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/mio_sync.sv
module mio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/mio_regs.sv
module mio_regs
  import mio_pkg::*;
#(
  parameter int W     = 8,
  parameter int SEL_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     dir_o,
  output logic [W-1:0]     lat_o,
  output logic             adis_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             start_o
);
  logic [W-1:0]     dir_q, lat_q;
  logic             adis_q, adis_d1_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q     <= '0;
      lat_q     <= '0;
      adis_q    <= 1'b1;
      sel_q     <= '0;
      adis_d1_q <= 1'b1;
    end else begin
      adis_d1_q <= adis_q;
      if (wr_en_i) begin
        unique case (reg_addr_e'(addr_i))
          A_DIR:   dir_q <= wdata_i;
          A_DATA:  lat_q <= wdata_i;
          A_CTRL: begin
            adis_q <= wdata_i[0];
            sel_q  <= wdata_i[SEL_W:1];
          end
          default: ;
        endcase
      end
    end
  end

  // falling edge of the disable flag
  assign start_o = adis_d1_q & ~adis_q;
  assign dir_o   = dir_q;
  assign lat_o   = lat_q;
  assign adis_o  = adis_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/mio_bit_mode.sv
module mio_bit_mode (
  input  logic dir_i,
  input  logic lat_i,
  input  logic adis_i,
  input  logic sel_hit_i,
  input  logic pin_i,
  output logic rd_o,
  output logic ana_en_o
);
  logic analog_mode;

  assign analog_mode = ~dir_i & ~lat_i;
  // output: latch; digital input: pin; analog (or fixed low): 0
  assign rd_o     = dir_i ? lat_i : (lat_i & pin_i);
  assign ana_en_o = analog_mode & ~adis_i & sel_hit_i;
endmodule

// File: rtl/mixed_io_port.sv
module mixed_io_port
  import mio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] ana_en_o,
  output logic         conv_start_o,
  output logic         dbg_ok_o
);
  localparam int SEL_W = $clog2(W);

  logic [W-1:0]     dir, lat, pin_s, port_rd;
  logic             adis;
  logic [SEL_W-1:0] sel;

  mio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pin_s)
  );

  mio_regs #(.W(W), .SEL_W(SEL_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .dir_o  (dir),
    .lat_o  (lat),
    .adis_o (adis),
    .sel_o  (sel),
    .start_o(conv_start_o)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    mio_bit_mode u_mode (
      .dir_i    (dir[i]),
      .lat_i    (lat[i]),
      .adis_i   (adis),
      .sel_hit_i(sel == SEL_W'(i)),
      .pin_i    (pin_s[i]),
      .rd_o     (port_rd[i]),
      .ana_en_o (ana_en_o[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      A_DIR:  rdata_o = dir;
      A_DATA: rdata_o = port_rd;
      A_CTRL: begin
        rdata_o[0]       = adis;
        rdata_o[SEL_W:1] = sel;
      end
      default: rdata_o = '0;
    endcase
  end

  assign pad_out_o = lat;
  assign pad_oe_o  = dir;
  assign dbg_ok_o  = lat[W-1];
endmodule

// File: rtl/mio_port_chk.sv
module mio_port_chk
  import mio_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] rdata_o,
  input logic [W-1:0] pad_out_o,
  input logic [W-1:0] pad_oe_o,
  input logic [W-1:0] ana_en_o,
  input logic         conv_start_o
);
  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_DIR) |=> pad_oe_o == $past(wdata_i));

  p_analog_read_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_DATA) |-> ((rdata_o & ~pad_oe_o & ~pad_out_o) == '0));

  p_start_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $past(wr_en_i && addr_i == A_CTRL && !wdata_i[0]));

  p_start_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  p_ana_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ana_en_o));

  p_ana_undriven_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ana_en_o & (pad_oe_o | pad_out_o)) == '0));
endmodule

bind mixed_io_port mio_port_chk #(.W(W)) u_chk (.*);

// File: tb/mixed_io_port_test.sv
module mixed_io_port_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] pad_in_i = 8'hFF;
  logic [7:0] rdata_o, pad_out_o, pad_oe_o, ana_en_o;
  logic       conv_start_o, dbg_ok_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  mixed_io_port uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); check("R1 dir", v, 8'h00);
    rd(2'd1, v); check("R1 port", v, 8'h00);
    rd(2'd2, v); check("R1 ctrl", v, 8'h01);
    rd(2'd3, v); check("R2 reserved", v, 8'h00);
    check("R1 oe", pad_oe_o, 8'h00);
    check("R1 ana", ana_en_o, 8'h00);
    check("R1 start", conv_start_o, 1'b0);
  endtask

  task automatic t_output();
    logic [7:0] v;
    @(negedge clk_i);
    addr_i = 2'd0; wdata_i = 8'hFF; wr_en_i = 1'b1;
    #1 check("R2 no early update", pad_oe_o, 8'h00);
    @(negedge clk_i); wr_en_i = 1'b0;
    check("R2 dir updated", pad_oe_o, 8'hFF);
    wr(2'd1, 8'hA5);
    check("R3 pad_out", pad_out_o, 8'hA5);
    rd(2'd1, v); check("R3 read latch", v, 8'hA5);
    rd(2'd0, v); check("R2 dir read", v, 8'hFF);
  endtask

  task automatic t_input();
    logic [7:0] v;
    @(negedge clk_i);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF);
    check("R3 oe off", pad_oe_o, 8'h00);
    pad_in_i = 8'h00;
    repeat (3) @(negedge clk_i);
    pad_in_i = 8'h3C;
    @(negedge clk_i);
    rd(2'd1, v); check("R4 one edge old", v, 8'h00);
    @(negedge clk_i);
    rd(2'd1, v); check("R4 two edges new", v, 8'h3C);
  endtask

  task automatic t_analog();
    logic [7:0] v;
    @(negedge clk_i);
    wr(2'd1, 8'h00);
    pad_in_i = 8'hFF;
    repeat (3) @(negedge clk_i);
    rd(2'd1, v); check("R5 adis1 reads 0", v, 8'h00);
    wr(2'd2, 8'h00);
    repeat (2) @(negedge clk_i);
    rd(2'd1, v); check("R5 adis0 reads 0", v, 8'h00);
    wr(2'd2, 8'h01);
    @(negedge clk_i);
  endtask

  task automatic t_conv();
    logic [7:0] v;
    @(negedge clk_i);
    wr(2'd2, {4'h0, 3'd2, 1'b0});
    check("R6 pulse high", conv_start_o, 1'b1);
    @(negedge clk_i);
    check("R6 pulse one cycle", conv_start_o, 1'b0);
    rd(2'd2, v); check("R2 ctrl read", v, 8'h04);
    wr(2'd2, {4'h0, 3'd2, 1'b0});
    check("R6 no pulse on 0->0", conv_start_o, 1'b0);
    wr(2'd2, 8'h01);
    check("R6 no pulse on 0->1", conv_start_o, 1'b0);
    @(negedge clk_i);
    check("R6 still quiet", conv_start_o, 1'b0);
  endtask

  task automatic t_chan();
    @(negedge clk_i);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    check("R7 adis1 no enable", ana_en_o, 8'h00);
    wr(2'd2, {4'h0, 3'd5, 1'b0});
    check("R7 select 5", ana_en_o, 8'h20);
    wr(2'd1, 8'h20);
    check("R7 latch1 off", ana_en_o, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h20);
    check("R7 output off", ana_en_o, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd2, {4'h0, 3'd0, 1'b0});
    check("R7 select 0", ana_en_o, 8'h01);
    wr(2'd2, 8'h01);
    check("R7 disabled", ana_en_o, 8'h00);
  endtask

  task automatic t_mixed();
    logic [7:0] v;
    logic [7:0] d = 8'hF0, l = 8'h3C, p = 8'hA5;
    @(negedge clk_i);
    wr(2'd0, d);
    wr(2'd1, l);
    pad_in_i = p;
    repeat (3) @(negedge clk_i);
    rd(2'd1, v); check("R8 mixed read", v, (d & l) | (~d & l & p));
    check("R8 mixed oe", pad_oe_o, d);
    check("R8 mixed out", pad_out_o, l);
  endtask

  task automatic t_dbg();
    @(negedge clk_i);
    wr(2'd1, 8'h80);
    check("R9 dbg set", dbg_ok_o, 1'b1);
    wr(2'd1, 8'h7F);
    check("R9 dbg clear", dbg_ok_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_output();
    t_input();
    t_analog();
    t_conv();
    t_chan();
    t_mixed();
    t_dbg();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule